// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer Channel

This block is one 16-bit channel of a timer. It watches a free-running counter that it does not own, and it shares one data register and one pin between two jobs. A mode bit picks the job. In compare mode the channel checks its register against the counter on every clock. When the two are equal, the channel sets a status flag and drives its output pin to a configured level, so the edge lands on an exact counter tick whatever software is doing at the time. In capture mode the channel watches its input pin and copies the counter into the register when a selected edge arrives.

Software reaches the channel through a byte-wide register bus with four addresses: the register high byte, the register low byte, a control byte and a status byte. To make a pulse, software loads the time of the leading edge with a drive-high action. After that match it adds the pulse width, loads the new value and selects drive-low. Repeating this sequence gives any chosen period and duty cycle.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the channel register reads 0xFF at both byte addresses, the control byte reads 0x00 (compare mode), the status byte reads 0x00, and pin_o and irq_o are low.
- R2: Address 0 reads and writes bits 15:8 of the channel register. Address 1 reads and writes bits 7:0. Reads always return the committed register.
- R3: A write to address 0 only loads a holding byte, so the register is unchanged. A write to address 1 commits the holding byte and the written byte to the register together, on the same clock edge.
- R4: In compare mode (control bit 0 = 0), on the clock edge where the register equals cnt_i, the status flag (status bit 0) is set.
- R5: On the first cycle after a commit, a match is ignored. The flag does not set and the pin does not change.
- R6: On a compare match, the pin action in control bits 2:1 is applied to pin_o on the same edge: 00 none, 01 toggle, 10 drive low, 11 drive high. pin_o holds its level between matches, so the pulse width equals the difference between the two programmed values.
- R7: In capture mode (control bit 0 = 1), on an edge of pin_i selected by control bits 4:3 (00 none, 01 rising, 10 falling, 11 both), the register loads the cnt_i value of that clock edge and the flag is set. An edge that is not selected has no effect.
- R8: In capture mode, equality between the register and the counter sets no flag and does not change pin_o.
- R9: Writing a byte with bit 0 = 1 to address 3 clears the flag. Writing bit 0 = 0 leaves the flag unchanged.
- R10: When a capture or match happens in the same cycle as a clear, the flag stays set.
- R11: irq_o is high exactly when the flag is set and control bit 5 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 1 | Capture input pin |
| pin_o | output | 1 | Compare output pin |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register byte address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that cnt_i is the output of a counter, that pin_i is already synchronous to clk_i, and that the bus makes at most one write per cycle. The bench drives the counter as a plain incrementer from reset and changes pin_i and the bus signals only on the falling clock edge. It also loads compare values relative to the counter, so that every match falls inside a short window and never needs the counter to wrap.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam logic [1:0] ADDR_VHI  = 2'd0;
  localparam logic [1:0] ADDR_VLO  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } pin_act_e;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  // bit 0 mode, 2:1 action, 4:3 edge, 5 irq enable
  typedef struct packed {
    logic      irq_en;
    edge_sel_e edg;
    pin_act_e  act;
    logic      cap_mode;
  } chan_ctrl_t;
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det
  import cc_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic pin_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    unique case (sel_i)
      EDG_RISE: hit_o = rise;
      EDG_FALL: hit_o = fall;
      EDG_BOTH: hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_val_reg.sv
module cc_val_reg #(
  parameter int W  = 16,
  parameter int BW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [W-1:0]  cap_val_i,
  output logic [W-1:0]  val_o
);
  localparam int HW = W - BW;

  logic [HW-1:0] hi_q;
  logic [W-1:0]  val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '1;
    else if (wr_hi_i) hi_q <= wdata_i[HW-1:0];
  end

  // capture wins over a same-cycle commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '1;
    else if (cap_i)   val_q <= cap_val_i;
    else if (wr_lo_i) val_q <= {hi_q, wdata_i};
  end

  assign val_o = val_q;
endmodule

// File: rtl/cc_cmp.sv
module cc_cmp #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         commit_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] cnt_i,
  output logic         match_o,
  output logic         sup_o
);
  logic sup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sup_q <= 1'b0;
    else         sup_q <= commit_i;
  end

  assign sup_o   = sup_q;
  assign match_o = en_i & ~sup_q & (val_i == cnt_i);
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cc_timer_pkg::*;
#(
  parameter  int CNT_W = 16,
  localparam int BUS_W = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  output logic             pin_o,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int CTRL_W = $bits(chan_ctrl_t);

  chan_ctrl_t       ctrl_q;
  logic             flag_q, pin_q;
  logic             cap_mode;
  pin_act_e         act;
  logic             wr_hi, wr_lo, wr_ctrl, clr;
  logic             edge_hit, cap, match, sup, ev;
  logic [CNT_W-1:0] val;

  assign cap_mode = ctrl_q.cap_mode;
  assign act      = ctrl_q.act;

  assign wr_hi   = wr_i && addr_i == ADDR_VHI;
  assign wr_lo   = wr_i && addr_i == ADDR_VLO;
  assign wr_ctrl = wr_i && addr_i == ADDR_CTRL;
  assign clr     = wr_i && addr_i == ADDR_STAT && wdata_i[0];

  cc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sel_i  (ctrl_q.edg),
    .hit_o  (edge_hit)
  );

  assign cap = cap_mode & edge_hit;

  cc_val_reg #(.W(CNT_W), .BW(BUS_W)) u_val (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hi_i   (wr_hi),
    .wr_lo_i   (wr_lo),
    .wdata_i   (wdata_i),
    .cap_i     (cap),
    .cap_val_i (cnt_i),
    .val_o     (val)
  );

  cc_cmp #(.W(CNT_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (~cap_mode),
    .commit_i (wr_lo),
    .val_i    (val),
    .cnt_i    (cnt_i),
    .match_o  (match),
    .sup_o    (sup)
  );

  assign ev = cap | match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= chan_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= 1'b0;
    else if (ev)  flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (match) begin
      unique case (act)
        ACT_TOG:  pin_q <= ~pin_q;
        ACT_LOW:  pin_q <= 1'b0;
        ACT_HIGH: pin_q <= 1'b1;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_VHI:  rdata_o = val[CNT_W-1:BUS_W];
      ADDR_VLO:  rdata_o = val[BUS_W-1:0];
      ADDR_CTRL: rdata_o = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      default:   rdata_o = {{(BUS_W-1){1'b0}}, flag_q};
    endcase
  end

  assign pin_o = pin_q;
  assign irq_o = flag_q & ctrl_q.irq_en;
endmodule

// File: rtl/cc_timer_chan_chk.sv
module cc_timer_chan_chk #(
  parameter int W  = 16,
  parameter int BW = W / 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cap_mode_i,
  input logic [1:0]    act_i,
  input logic [W-1:0]  cnt_i,
  input logic [W-1:0]  val_i,
  input logic          sup_i,
  input logic          flag_i,
  input logic          ev_i,
  input logic          pin_o_i,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [BW-1:0] wdata_i
);
  logic clr_req;
  assign clr_req = wr_i && addr_i == 2'd3 && wdata_i[0];

  // R4
  cmp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && !sup_i && val_i == cnt_i) |=> flag_i);

  // R5
  sup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && sup_i && !clr_req) |=> $stable(flag_i));

  // R3
  hi_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0 && !cap_mode_i) |=> $stable(val_i));

  // R6
  drive_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && !sup_i && val_i == cnt_i && act_i == 2'b11) |=> pin_o_i);

  // R8
  cap_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode_i |=> $stable(pin_o_i));

  // R10
  clr_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && ev_i) |=> flag_i);
endmodule

bind cc_timer_chan cc_timer_chan_chk #(.W(CNT_W), .BW(BUS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_mode_i (cap_mode),
  .act_i      (act),
  .cnt_i      (cnt_i),
  .val_i      (val),
  .sup_i      (sup),
  .flag_i     (flag_q),
  .ev_i       (ev),
  .pin_o_i    (pin_o),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i)
);

// File: tb/sim_cc_timer_chan.sv
module sim_cc_timer_chan;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt;
  logic        pin_i = 1'b0;
  logic        pin_o;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  cc_timer_chan u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .cnt_i   (cnt),
    .pin_i   (pin_i),
    .pin_o   (pin_o),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 16'd0;
    else        cnt <= cnt + 16'd1;
  end

  // behavioural reference model
  logic [15:0] m_val;
  logic [7:0]  m_hbuf;
  logic [5:0]  m_ctrl;
  logic        m_flag, m_pin, m_pq, m_sup;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val = 16'hFFFF; m_hbuf = 8'hFF; m_ctrl = 6'd0;
      m_flag = 1'b0; m_pin = 1'b0; m_pq = 1'b0; m_sup = 1'b0;
    end else begin
      bit ev, clr, nsup, capm, rise, fall;
      ev = 0; clr = 0; nsup = 0;
      capm = m_ctrl[0];
      rise = pin_i && !m_pq;
      fall = !pin_i && m_pq;
      if (!capm) begin
        if (m_val == cnt && !m_sup) begin
          ev = 1;
          case (m_ctrl[2:1])
            2'd1: m_pin = !m_pin;
            2'd2: m_pin = 1'b0;
            2'd3: m_pin = 1'b1;
            default: ;
          endcase
        end
      end else begin
        case (m_ctrl[4:3])
          2'd1: ev = rise;
          2'd2: ev = fall;
          2'd3: ev = rise || fall;
          default: ev = 0;
        endcase
      end
      if (wr) begin
        case (addr)
          2'd0: m_hbuf = wdata;
          2'd1: begin m_val = {m_hbuf, wdata}; nsup = 1; end
          2'd2: m_ctrl = wdata[5:0];
          default: clr = wdata[0];
        endcase
      end
      if (ev && capm) m_val = cnt;
      if (ev) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      m_sup = nsup;
      m_pq = pin_i;
    end
  end

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_val[15:8];
      2'd1: return m_val[7:0];
      2'd2: return {2'b00, m_ctrl};
      default: return {7'd0, m_flag};
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (rdata !== m_rd(addr) || pin_o !== m_pin || irq !== (m_flag && m_ctrl[5])) begin
        n_fail++;
        $display("FAIL R2/R6/R11 model a=%0d rdata=%h/%h pin=%b/%b irq=%b/%b (act/exp)",
                 addr, rdata, m_rd(addr), pin_o, m_pin, irq, m_flag && m_ctrl[5]);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cyc();
    wr = 1'b1; addr = a; wdata = d;
    cyc();
    wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  logic [15:0] last_v;

  task automatic wr16_abs(input logic [15:0] v);
    cyc();
    wr = 1'b1; addr = 2'd0; wdata = v[15:8];
    cyc();
    addr = 2'd1; wdata = v[7:0];
    cyc();
    wr = 1'b0;
    last_v = v;
  endtask

  // value relative to the counter sampled by the high-byte write
  task automatic wr16_rel(input int off);
    logic [15:0] v;
    cyc();
    v = cnt + 16'(off);
    wr = 1'b1; addr = 2'd0; wdata = v[15:8];
    cyc();
    addr = 2'd1; wdata = v[7:0];
    cyc();
    wr = 1'b0;
    last_v = v;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd0, h);
    rd(2'd1, l);
    v = {h, l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, exp_v, t_rise, t_fall;
    logic        p0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(2'd0, b); chk("R1 hi", b, 8'hFF);
    rd(2'd1, b); chk("R1 lo", b, 8'hFF);
    rd(2'd2, b); chk("R1 ctrl", b, 8'h00);
    rd(2'd3, b); chk("R1 stat", b, 8'h00);
    chk("R1 pin", pin_o, 0);
    chk("R1 irq", irq, 0);

    // R3 buffered high byte, R2 byte positions
    bus_wr(2'd0, 8'h12);
    rd(2'd0, b); chk("R3 hi held", b, 8'hFF);
    bus_wr(2'd1, 8'h34);
    rd(2'd0, b); chk("R2 hi", b, 8'h12);
    rd(2'd1, b); chk("R2 lo", b, 8'h34);

    // R4 exact match timing, R6 drive high
    bus_wr(2'd2, 8'h06);
    bus_wr(2'd3, 8'h01);
    wr16_rel(20);
    for (int i = 0; i < 60; i++) begin cyc(); if (pin_o) break; end
    t_rise = cnt;
    chk("R4 match tick", t_rise, last_v + 16'd1);
    rd(2'd3, b); chk("R4 flag", b, 8'h01);
    // R9 write 0 keeps, write 1 clears
    bus_wr(2'd3, 8'h00);
    rd(2'd3, b); chk("R9 keep", b, 8'h01);
    bus_wr(2'd3, 8'h01);
    rd(2'd3, b); chk("R9 clear", b, 8'h00);
    // R6 pulse trailing edge, drive low with irq enabled
    bus_wr(2'd2, 8'h24);
    wr16_abs(last_v + 16'd40);
    for (int i = 0; i < 80; i++) begin cyc(); if (!pin_o) break; end
    t_fall = cnt;
    chk("R6 width", t_fall - t_rise, 40);
    chk("R11 irq set", irq, 1);
    bus_wr(2'd3, 8'h01);
    chk("R11 irq clr", irq, 0);

    // R6 toggle
    bus_wr(2'd2, 8'h02);
    wr16_rel(10);
    wait_cyc(15);
    chk("R6 toggle", pin_o, 1);
    // R6 no action still flags
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h01);
    wr16_rel(10);
    wait_cyc(15);
    chk("R6 none pin", pin_o, 1);
    rd(2'd3, b); chk("R4 none flag", b, 8'h01);

    // R5 match right after commit is ignored
    bus_wr(2'd3, 8'h01);
    wr16_rel(2);
    wait_cyc(5);
    rd(2'd3, b); chk("R5 suppressed", b, 8'h00);
    wr16_rel(3);
    wait_cyc(5);
    rd(2'd3, b); chk("R5 next tick", b, 8'h01);

    // R7 capture on rising edge
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd2, 8'h09);
    cyc();
    exp_v = cnt; pin_i = 1'b1;
    wait_cyc(2);
    rd16(v); chk("R7 rise val", v, exp_v);
    rd(2'd3, b); chk("R7 rise flag", b, 8'h01);
    bus_wr(2'd3, 8'h01);
    cyc(); pin_i = 1'b0;
    wait_cyc(2);
    rd(2'd3, b); chk("R7 fall ignored", b, 8'h00);
    rd16(v); chk("R7 val kept", v, exp_v);
    // falling select
    bus_wr(2'd2, 8'h11);
    cyc(); pin_i = 1'b1;
    wait_cyc(2);
    rd(2'd3, b); chk("R7 rise ignored", b, 8'h00);
    cyc(); exp_v = cnt; pin_i = 1'b0;
    wait_cyc(2);
    rd16(v); chk("R7 fall val", v, exp_v);
    rd(2'd3, b); chk("R7 fall flag", b, 8'h01);
    // both edges
    bus_wr(2'd2, 8'h19);
    bus_wr(2'd3, 8'h01);
    cyc(); exp_v = cnt; pin_i = 1'b1;
    wait_cyc(2);
    rd16(v); chk("R7 both val", v, exp_v);
    rd(2'd3, b); chk("R7 both flag", b, 8'h01);

    // R8 capture mode: no compare, pin held; edge select off
    bus_wr(2'd2, 8'h05);
    bus_wr(2'd3, 8'h01);
    p0 = pin_o;
    wr16_rel(4);
    cyc(); pin_i = 1'b0;
    wait_cyc(8);
    chk("R8 pin held", pin_o, p0);
    rd(2'd3, b); chk("R8 no flag", b, 8'h00);
    rd16(v); chk("R7 off keeps val", v, last_v);

    // R10 capture same cycle as clear
    bus_wr(2'd2, 8'h09);
    cyc();
    pin_i = 1'b1; wr = 1'b1; addr = 2'd3; wdata = 8'h01;
    cyc();
    wr = 1'b0;
    rd(2'd3, b); chk("R10 event wins", b, 8'h01);
    wait_cyc(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule